// File: doc/BRIEF.md
# Paged Two-Wire Management Register Slave

This block is the serial management front end of a pluggable module. A host drives SCL and an open-drain SDA line. The slave answers at bus address 0x50 (A0h for a write, A1h for a read) and gives access to a 256-byte space. Addresses below 128 always reach one fixed lower page that holds flags and status. Addresses 128 and above form a window whose contents depend on a page-select byte.

An active-low select input gates the slave so that several modules can share one bus. The slave starts to answer only after select has been low for a set number of clock cycles. It stops answering after select has been high for another set number.

Lower-page bytes and upper pages 0 and 3 are served through a register port to the module's flag and status logic. Upper page 2 is a user scratch area held inside the block. Each completed host read of a lower-page byte raises a strobe so that the flag logic can clear the latched bits of that byte.

Top module: `paged_mgmt_slave`

## Requirements
- R1: The slave never drives SDA and ignores all traffic unless select has been low for SEL_ON_CYC cycles. Once select has been high for SEL_OFF_CYC cycles, it releases SDA and drops back to idle.
- R2: The slave ACKs only the device byte whose upper seven bits are 0x50, where bit 0 set to 1 means read. Any other device byte is NACKed, and the transfer that follows has no effect.
- R3: A byte written to lower-page address 0..126 raises rf_wr_o for one cycle, with that address on rf_ev_addr_o and the byte on rf_wdata_o.
- R4: Address 127 is the page-select byte and reads back its current value. A write of 0, 2 or 3 is stored. A write of any other value is ignored.
- R5: With page 2 selected, addresses 128..255 are a user area inside the block that stores writes and returns them on reads, and raises no rf_wr_o. With page 0 or 3 selected, those addresses go to the register port, with the page on rf_page_o.
- R6: Each lower-page byte that the host reads raises rf_rd_done_o for one cycle, with its address on rf_ev_addr_o, once the master's ACK or NACK bit has been sampled. Reads of upper-page bytes raise no strobe.
- R7: After every data byte, read or written, the word address advances by one and wraps within its own 128-byte half: 127 goes to 0, and 255 goes to 128.
- R8: The slave ACKs its own address and every written byte. On reads, a master NACK ends the transfer, and SDA stays released until the next start condition.
- R9: A stop condition, a repeated start, or deselection returns the slave to idle and keeps the word address. A repeated start begins a new device-byte phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_ni | input | 1 | Module select, active low |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_oe_o | output | 1 | Pulls SDA low when 1 (open drain) |
| rf_addr_o | output | AW | Current word address, used for read lookup |
| rf_page_o | output | DW | Current page-select value |
| rf_rdata_i | input | DW | Register port read data for rf_addr_o |
| rf_wr_o | output | 1 | One-cycle write strobe |
| rf_wdata_o | output | DW | Write data |
| rf_ev_addr_o | output | AW | Address of the write or read-done event |
| rf_rd_done_o | output | 1 | One-cycle strobe after a lower-page byte has been read |

## Verification
Writes and reads are tried as single bytes, as bursts that cross the 127/0 and 255/128 wrap points, and as random reads built from a word-address write and a repeated start. Together these separate the handling of the write pointer from that of the read pointer. Page select is driven with legal and illegal values, then read back through address 127 and through the upper window. This shows whether data lands in the internal user page or on the register port. Deselection before a transfer and in the middle of one, a foreign device address, and a master NACK each test whether the slave keeps SDA released and leaves memory untouched.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_DEV, ST_DEV_ACK, ST_WADR, ST_WADR_ACK,
    ST_WDAT, ST_WDAT_ACK, ST_RDAT, ST_RACK
  } bus_state_e;

  localparam logic [6:0] DEV_ADDR7 = 7'h50;
  localparam int unsigned USER_PAGE = 2;

  function automatic logic page_ok(input logic [7:0] p);
    return (p == 8'd0) || (p == 8'd2) || (p == 8'd3);
  endfunction
endpackage

// File: rtl/mgmt_sel_gate.sv
module mgmt_sel_gate #(
  parameter int unsigned ON_CYC  = 20000,
  parameter int unsigned OFF_CYC = 20000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sel_ni,
  output logic active_o
);
  localparam int unsigned MAXC = (ON_CYC > OFF_CYC) ? ON_CYC : OFF_CYC;
  localparam int unsigned CW   = $clog2(MAXC + 1);

  logic [1:0]    sel_q;
  logic          active_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim;

  assign lim = active_q ? CW'(OFF_CYC - 1) : CW'(ON_CYC - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q    <= 2'b11;
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else begin
      sel_q <= {sel_q[0], sel_ni};
      if (!sel_q[1] == active_q) begin
        cnt_q <= '0;
      end else if (cnt_q == lim) begin
        active_q <= ~active_q;
        cnt_q    <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign active_o = active_q;

  // R1
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CW'(MAXC));
endmodule

// File: rtl/mgmt_bus_phy.sv
module mgmt_bus_phy #(
  parameter int unsigned SYNC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s_o,
  output logic sda_s_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [SYNC:0] scl_q, sda_q;
  logic scl_s, scl_p, sda_s, sda_p;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= '1;
      sda_q <= '1;
    end else begin
      scl_q <= {scl_q[SYNC-1:0], scl_i};
      sda_q <= {sda_q[SYNC-1:0], sda_i};
    end
  end

  assign scl_s = scl_q[SYNC-1];
  assign scl_p = scl_q[SYNC];
  assign sda_s = sda_q[SYNC-1];
  assign sda_p = sda_q[SYNC];

  assign scl_s_o    = scl_s;
  assign sda_s_o    = sda_s;
  assign scl_rise_o = scl_s & ~scl_p;
  assign scl_fall_o = ~scl_s & scl_p;
  // SDA edges while SCL stays high
  assign start_o    = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_o     = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/mgmt_user_page.sv
module mgmt_user_page #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 128,
  localparam int unsigned IW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [IW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [IW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/paged_mgmt_slave.sv
module paged_mgmt_slave
  import mgmt_pkg::*;
#(
  parameter int unsigned AW          = 8,
  parameter int unsigned DW          = 8,
  parameter int unsigned SEL_ON_CYC  = 20000,
  parameter int unsigned SEL_OFF_CYC = 20000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sel_ni,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe_o,
  output logic [AW-1:0] rf_addr_o,
  output logic [DW-1:0] rf_page_o,
  input  logic [DW-1:0] rf_rdata_i,
  output logic          rf_wr_o,
  output logic [DW-1:0] rf_wdata_o,
  output logic [AW-1:0] rf_ev_addr_o,
  output logic          rf_rd_done_o
);
  localparam int unsigned HALF = 1 << (AW - 1);
  localparam int unsigned CW   = $clog2(DW + 1);
  localparam logic [AW-1:0] PSEL_ADDR = AW'(HALF - 1);
  localparam logic [CW-1:0] BITS      = CW'(DW);

  logic active, scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  mgmt_sel_gate #(.ON_CYC(SEL_ON_CYC), .OFF_CYC(SEL_OFF_CYC)) u_sel (
    .clk_i, .rst_ni, .sel_ni, .active_o(active)
  );

  mgmt_bus_phy #(.SYNC(2)) u_phy (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_s_o(scl_s), .sda_s_o(sda_s), .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall), .start_o(start_det), .stop_o(stop_det)
  );

  bus_state_e      state_q;
  logic [CW-1:0]   cnt_q;
  logic [DW-1:0]   sh_q, page_q, wd_q, uw_d_q, up_rdata, rd_byte;
  logic [AW-1:0]   ptr_q, ev_q, ptr_inc;
  logic [AW-2:0]   uw_a_q;
  logic            oe_q, rw_q, mack_q, wr_q, rdd_q, uw_we_q;

  mgmt_user_page #(.DW(DW), .DEPTH(HALF)) u_upage (
    .clk_i, .we_i(uw_we_q), .waddr_i(uw_a_q), .wdata_i(uw_d_q),
    .raddr_i(ptr_q[AW-2:0]), .rdata_o(up_rdata)
  );

  // wrap inside the current 128-byte half
  assign ptr_inc = {ptr_q[AW-1], ptr_q[AW-2:0] + 1'b1};

  always_comb begin
    if (ptr_q == PSEL_ADDR)                            rd_byte = page_q;
    else if (ptr_q[AW-1] && page_q == DW'(USER_PAGE)) rd_byte = up_rdata;
    else                                               rd_byte = rf_rdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      ptr_q   <= '0;
      page_q  <= '0;
      oe_q    <= 1'b0;
      rw_q    <= 1'b0;
      mack_q  <= 1'b0;
      wr_q    <= 1'b0;
      rdd_q   <= 1'b0;
      ev_q    <= '0;
      wd_q    <= '0;
      uw_we_q <= 1'b0;
      uw_a_q  <= '0;
      uw_d_q  <= '0;
    end else begin
      wr_q    <= 1'b0;
      rdd_q   <= 1'b0;
      uw_we_q <= 1'b0;
      if (!active || stop_det) begin
        state_q <= ST_IDLE;
        oe_q    <= 1'b0;
      end else if (start_det) begin
        state_q <= ST_DEV;
        cnt_q   <= '0;
        oe_q    <= 1'b0;
      end else begin
        case (state_q)
          ST_DEV, ST_WADR, ST_WDAT: begin
            if (scl_rise) begin
              sh_q  <= {sh_q[DW-2:0], sda_s};
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall && cnt_q == BITS) begin
              cnt_q <= '0;
              if (state_q == ST_DEV) begin
                if (sh_q[DW-1:1] == DEV_ADDR7) begin
                  oe_q    <= 1'b1;
                  rw_q    <= sh_q[0];
                  state_q <= ST_DEV_ACK;
                end else begin
                  state_q <= ST_IDLE;
                end
              end else if (state_q == ST_WADR) begin
                ptr_q   <= sh_q[AW-1:0];
                oe_q    <= 1'b1;
                state_q <= ST_WADR_ACK;
              end else begin
                oe_q    <= 1'b1;
                state_q <= ST_WDAT_ACK;
                ptr_q   <= ptr_inc;
                if (ptr_q == PSEL_ADDR) begin
                  if (page_ok(8'(sh_q))) page_q <= sh_q;
                end else if (ptr_q[AW-1] && page_q == DW'(USER_PAGE)) begin
                  uw_we_q <= 1'b1;
                  uw_a_q  <= ptr_q[AW-2:0];
                  uw_d_q  <= sh_q;
                end else begin
                  wr_q <= 1'b1;
                  ev_q <= ptr_q;
                  wd_q <= sh_q;
                end
              end
            end
          end
          ST_DEV_ACK: if (scl_fall) begin
            cnt_q <= '0;
            if (rw_q) begin
              sh_q    <= rd_byte;
              oe_q    <= ~rd_byte[DW-1];
              state_q <= ST_RDAT;
            end else begin
              oe_q    <= 1'b0;
              state_q <= ST_WADR;
            end
          end
          ST_WADR_ACK, ST_WDAT_ACK: if (scl_fall) begin
            oe_q    <= 1'b0;
            cnt_q   <= '0;
            state_q <= ST_WDAT;
          end
          ST_RDAT: begin
            if (scl_rise) begin
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall) begin
              if (cnt_q == BITS) begin
                oe_q    <= 1'b0;
                state_q <= ST_RACK;
              end else begin
                sh_q <= {sh_q[DW-2:0], 1'b0};
                oe_q <= ~sh_q[DW-2];
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              mack_q <= ~sda_s;
              ptr_q  <= ptr_inc;
              if (!ptr_q[AW-1]) begin
                rdd_q <= 1'b1;
                ev_q  <= ptr_q;
              end
            end else if (scl_fall) begin
              cnt_q <= '0;
              if (mack_q) begin
                sh_q    <= rd_byte;
                oe_q    <= ~rd_byte[DW-1];
                state_q <= ST_RDAT;
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o     = oe_q;
  assign rf_addr_o    = ptr_q;
  assign rf_page_o    = page_q;
  assign rf_wr_o      = wr_q;
  assign rf_wdata_o   = wd_q;
  assign rf_ev_addr_o = ev_q;
  assign rf_rd_done_o = rdd_q;

  // R1
  sda_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active |=> !sda_oe_o);
  // R4
  page_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    page_ok(8'(page_q)));
  // R3
  wr_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_wr_o |=> !rf_wr_o);
  // R6
  rd_done_lower_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_rd_done_o |-> !rf_ev_addr_o[AW-1]);
  // R8
  ack_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DEV_ACK || state_q == ST_WADR_ACK || state_q == ST_WDAT_ACK) |-> sda_oe_o);
  // R9
  stop_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> state_q == ST_IDLE);
endmodule

// File: tb/paged_mgmt_slave_tb.sv
module paged_mgmt_slave_tb;
  localparam int Q   = 8;
  localparam int SEL = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_n = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe, rf_wr, rf_rd_done;
  logic [7:0] rf_addr, rf_page, rf_rdata, rf_wdata, rf_ev_addr;
  logic sda_line;

  int nchk = 0, nerr = 0, wr_cnt = 0, rd_cnt = 0;
  logic [7:0] last_wr_page, last_rd_addr;
  logic done = 1'b0;
  logic [7:0] ext_mem [4][256];

  always #2.5 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;
  assign rf_rdata = ext_mem[rf_addr[7] ? rf_page[1:0] : 2'd0][rf_addr];

  paged_mgmt_slave #(.SEL_ON_CYC(SEL), .SEL_OFF_CYC(SEL)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sel_ni(sel_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .rf_addr_o(rf_addr), .rf_page_o(rf_page), .rf_rdata_i(rf_rdata),
    .rf_wr_o(rf_wr), .rf_wdata_o(rf_wdata), .rf_ev_addr_o(rf_ev_addr), .rf_rd_done_o(rf_rd_done)
  );

  function automatic logic [7:0] pat(input int p, input int a);
    return 8'(a) ^ 8'(p << 4) ^ 8'h5A;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < 4; p++)
        for (int a = 0; a < 256; a++) ext_mem[p][a] <= pat(p, a);
    end else begin
      if (rf_wr) begin
        ext_mem[rf_ev_addr[7] ? rf_page[1:0] : 2'd0][rf_ev_addr] <= rf_wdata;
        wr_cnt <= wr_cnt + 1;
        last_wr_page <= rf_page;
      end
      if (rf_rd_done) begin
        rd_cnt <= rd_cnt + 1;
        last_rd_addr <= rf_ev_addr;
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(1); scl_m = 1'b1; wq(1); sda_m = 1'b0; wq(1); scl_m = 1'b0; wq(1);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(1); scl_m = 1'b1; wq(1); sda_m = 1'b1; wq(1);
  endtask

  task automatic bit_out(input logic b);
    sda_m = b; wq(1); scl_m = 1'b1; wq(2); scl_m = 1'b0; wq(1);
  endtask

  task automatic bit_in(output logic b);
    sda_m = 1'b1; wq(1); scl_m = 1'b1; wq(1); b = sda_line; wq(1); scl_m = 1'b0; wq(1);
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) bit_out(d[i]);
    bit_in(b);
    ack = ~b;
  endtask

  task automatic recv_byte(input logic nack, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      bit_in(b);
      d[i] = b;
    end
    bit_out(nack);
  endtask

  task automatic write1(input logic [7:0] wa, input logic [7:0] d);
    logic a;
    bus_start(); send_byte(8'hA0, a); send_byte(wa, a); send_byte(d, a); bus_stop();
  endtask

  task automatic read1(input logic [7:0] wa, output logic [7:0] d);
    logic a;
    bus_start(); send_byte(8'hA0, a); send_byte(wa, a);
    bus_start(); send_byte(8'hA1, a); recv_byte(1'b1, d); bus_stop();
  endtask

  task automatic t_reset();
    check("R1 reset sda_oe", int'(sda_oe), 0);
    check("R3 reset rf_wr", int'(rf_wr), 0);
    check("R6 reset rd_done", int'(rf_rd_done), 0);
  endtask

  task automatic t_deselected();
    logic a0, a1, a2;
    bus_start(); send_byte(8'hA0, a0); send_byte(8'h10, a1); send_byte(8'h55, a2); bus_stop();
    check("R1 deselected addr ack", int'(a0), 0);
    check("R1 deselected data ack", int'(a2), 0);
    check("R1 deselected no write", wr_cnt, 0);
    sel_n = 1'b0;
    repeat (3 * SEL) @(negedge clk);
  endtask

  task automatic t_bad_addr();
    logic a, a1, a2, a3;
    int w0 = wr_cnt;
    bus_start(); send_byte(8'hA2, a); send_byte(8'h20, a1); send_byte(8'h11, a1); bus_stop();
    check("R2 foreign addr nack", int'(a), 0);
    check("R2 foreign no write", wr_cnt, w0);
    bus_start(); send_byte(8'hA0, a1); send_byte(8'h20, a2); send_byte(8'h77, a3); bus_stop();
    check("R2 own addr ack", int'(a1), 1);
    check("R3 lower write data", int'(ext_mem[0][8'h20]), 8'h77);
    check("R3 single write strobe", wr_cnt, w0 + 1);
  endtask

  task automatic t_lower_burst();
    logic a0, a1, a2, a3;
    bus_start(); send_byte(8'hA0, a0); send_byte(8'h05, a1);
    send_byte(8'h3C, a2); send_byte(8'hC3, a3); bus_stop();
    check("R8 addr ack", int'(a0 & a1), 1);
    check("R8 data acks", int'(a2 & a3), 1);
    check("R3 byte 5", int'(ext_mem[0][5]), 8'h3C);
    check("R7 byte 6", int'(ext_mem[0][6]), 8'hC3);
  endtask

  task automatic t_clear_on_read();
    logic [7:0] d;
    int r0 = rd_cnt;
    read1(8'h05, d);
    check("R3 read back byte 5", int'(d), 8'h3C);
    check("R6 one rd_done", rd_cnt, r0 + 1);
    check("R6 rd_done addr", int'(last_rd_addr), 5);
  endtask

  task automatic t_lower_wrap();
    logic a;
    logic [7:0] d0, d1, d2;
    int r0 = rd_cnt;
    bus_start(); send_byte(8'hA0, a); send_byte(8'd126, a);
    bus_start(); send_byte(8'hA1, a);
    recv_byte(1'b0, d0); recv_byte(1'b0, d1); recv_byte(1'b1, d2); bus_stop();
    check("R7 byte 126", int'(d0), int'(pat(0, 126)));
    check("R4 page byte reads 0", int'(d1), 0);
    check("R7 wrap to byte 0", int'(d2), int'(pat(0, 0)));
    check("R6 three strobes", rd_cnt, r0 + 3);
    check("R6 last strobe addr 0", int'(last_rd_addr), 0);
  endtask

  task automatic t_page_sel();
    logic [7:0] d;
    write1(8'd127, 8'd2); read1(8'd127, d);
    check("R4 legal page 2", int'(d), 2);
    write1(8'd127, 8'd5); read1(8'd127, d);
    check("R4 page 5 ignored", int'(d), 2);
    write1(8'd127, 8'd1); read1(8'd127, d);
    check("R4 page 1 ignored", int'(d), 2);
  endtask

  task automatic t_user_page();
    logic a;
    logic [7:0] d;
    int w0 = wr_cnt;
    int r0 = rd_cnt;
    bus_start(); send_byte(8'hA0, a); send_byte(8'd255, a);
    send_byte(8'hA5, a); send_byte(8'h5A, a); bus_stop();
    check("R5 user page no rf write", wr_cnt, w0);
    read1(8'd255, d);
    check("R5 user byte 255", int'(d), 8'hA5);
    read1(8'd128, d);
    check("R7 upper wrap to 128", int'(d), 8'h5A);
    check("R6 no strobe for upper", rd_cnt, r0);
  endtask

  task automatic t_page3();
    logic [7:0] d;
    write1(8'd127, 8'd3);
    write1(8'h90, 8'hE1);
    check("R5 page 3 forwarded", int'(ext_mem[3][8'h90]), 8'hE1);
    check("R5 page 3 on rf_page", int'(last_wr_page), 3);
    read1(8'h91, d);
    check("R5 page 3 read", int'(d), int'(pat(3, 8'h91)));
  endtask

  task automatic t_deselect_mid();
    logic a0, a1, a2;
    int w0 = wr_cnt;
    bus_start(); send_byte(8'hA0, a0); send_byte(8'h40, a1);
    sel_n = 1'b1; repeat (3 * SEL) @(negedge clk);
    check("R1 released after deselect", int'(sda_oe), 0);
    sel_n = 1'b0; repeat (3 * SEL) @(negedge clk);
    send_byte(8'h99, a2); bus_stop();
    check("R9 data after deselect nack", int'(a2), 0);
    check("R9 no write after deselect", wr_cnt, w0);
    check("R9 byte 0x40 untouched", int'(ext_mem[0][8'h40]), int'(pat(0, 8'h40)));
  endtask

  task automatic t_nack_release();
    logic a, b;
    logic [7:0] d;
    bus_start(); send_byte(8'hA0, a); send_byte(8'h00, a);
    bus_start(); send_byte(8'hA1, a); recv_byte(1'b1, d);
    bit_in(b);
    check("R8 sda released after nack", int'(b), 1);
    bus_stop();
  endtask

  task automatic t_stop_keeps_ptr();
    logic a;
    logic [7:0] d;
    bus_start(); send_byte(8'hA0, a); send_byte(8'h30, a); bus_stop();
    bus_start(); send_byte(8'hA1, a); recv_byte(1'b1, d); bus_stop();
    check("R9 pointer kept over stop", int'(d), int'(pat(0, 8'h30)));
    bus_start(); send_byte(8'hA0, a); send_byte(8'h31, a); send_byte(8'h11, a);
    bus_start(); send_byte(8'hA1, a); recv_byte(1'b1, d); bus_stop();
    check("R9 repeated start reads next", int'(d), int'(pat(0, 8'h32)));
    check("R9 write before restart", int'(ext_mem[0][8'h31]), 8'h11);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_deselected();
    t_bad_addr();
    t_lower_burst();
    t_clear_on_read();
    t_lower_wrap();
    t_page_sel();
    t_user_page();
    t_page3();
    t_deselect_mid();
    t_nack_release();
    t_stop_keeps_ptr();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule